// File: doc/BRIEF.md
# Serial Flash Write-Protection Controller

This block keeps the protection fields of a serial flash status register and rules on every program or erase request before it reaches the array. Four block-protect bits select a protected region at the top of a 1 MB byte-addressed array. The region starts at zero and doubles in steps up to half the array, and the upper codes cover the whole array. A lock bit, together with the active-low write-protect pin, can freeze those fields against further status-register writes.

The surrounding command logic pulses a status-write strobe with a data byte when a status write command arrives. It presents a request with a byte address and a chip-erase flag for each program, sector erase or chip erase. One cycle later the block answers with either a grant pulse or a deny pulse. The status byte it presents combines its own fields with three bits that other logic supplies.

Top module: `wp_ctrl`

## Requirements
- R1: After reset the four block-protect bits read 1 (status bits 5..2 = 1111) and the lock bit (status bit 7) reads 0.
- R2: While the write-protect pin is high, a status write loads the lock bit from data bit 7 and block-protect bits 3..0 from data bits 5..2, whatever the lock bit holds.
- R3: While the write-protect pin is low and the lock bit is 0, a status write loads those fields the same way.
- R4: While the write-protect pin is low and the lock bit is 1, a status write leaves the lock bit and all block-protect bits unchanged.
- R5: With block-protect bits 2..0 equal to 000, a program or sector erase to any address is granted.
- R6: Codes 001, 010, 011 and 100 in bits 2..0 protect the addresses from 0xF0000, 0xE0000, 0xC0000 and 0x80000 respectively up to 0xFFFFF. A request inside that range is denied and a request below it is granted.
- R7: Codes 101, 110 and 111 in bits 2..0 protect the whole array, so every program or sector erase is denied.
- R8: Block-protect bit 3 has no effect on which addresses are protected.
- R9: A chip erase (flag high) is granted only when all four block-protect bits are 0, and is denied otherwise. Its address is ignored.
- R10: Each request produces exactly one pulse, grant or deny, one cycle wide, in the cycle after the request. No pulse appears in a cycle after one with no request.
- R11: A status write takes effect on the clock edge that samples its strobe. A request sampled on that same edge is judged with the protection bits held before the write.
- R12: Status bits 0, 1 and 6 carry the supplied side bits aux[0], aux[1] and aux[2] unchanged and in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sr_wr | input | 1 | Status-register write strobe |
| sr_wdata | input | 8 | Status-register write byte |
| wp_n | input | 1 | Write-protect pin level, active low |
| aux | input | 3 | Side bits shown at status bits 0, 1, 6 |
| req_valid | input | 1 | Program/erase request strobe |
| req_addr | input | 20 | Request byte address |
| req_chip | input | 1 | Request is a chip erase |
| status | output | 8 | Current status byte |
| grant | output | 1 | One-cycle grant pulse |
| deny | output | 1 | One-cycle deny pulse |

## Verification
The assertions assume that the strobes, the write-protect level and the address are clean, defined values at every sampling edge after reset. They assume nothing about the spacing of requests, so a request may come in every cycle, including the cycle of a status write. The stimulus changes inputs only just after the falling edge and holds each value for one full cycle. It returns the strobes to zero between operations unless it is deliberately issuing a status write and a request together. Within these limits it covers all eight region codes with both values of bit 3, and addresses at and just below each region boundary.

// File: rtl/wp_pkg.sv
package wp_pkg;
    localparam int STATUS_W = 8;
    localparam int BP_W     = 4;
    localparam int BP_LSB   = 2;
    localparam int LOCK_POS = 7;

    typedef struct packed {
        logic            lock;
        logic [BP_W-1:0] bp;
    } prot_t;

    typedef enum logic [1:0] {
        V_IDLE  = 2'b00,
        V_GRANT = 2'b01,
        V_DENY  = 2'b10
    } verdict_e;

    function automatic prot_t unpack_wdata(input logic [STATUS_W-1:0] d);
        prot_t p;
        p.lock = d[LOCK_POS];
        p.bp   = d[BP_LSB +: BP_W];
        return p;
    endfunction

    function automatic logic [STATUS_W-1:0] pack_status(input prot_t p, input logic [2:0] side);
        logic [STATUS_W-1:0] s;
        s = '0;
        s[0] = side[0];
        s[1] = side[1];
        s[BP_LSB +: BP_W] = p.bp;
        s[6] = side[2];
        s[LOCK_POS] = p.lock;
        return s;
    endfunction
endpackage

// File: rtl/wp_status_reg.sv
module wp_status_reg
    import wp_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                sr_wr,
    input  logic [STATUS_W-1:0] sr_wdata,
    input  logic                wp_n,
    output prot_t               prot
);
    logic may_write;
    assign may_write = wp_n || !prot.lock;

    always_ff @(posedge clk) begin
        if (rst) begin
            prot.lock <= 1'b0;
            prot.bp   <= '1;
        end else if (sr_wr && may_write) begin
            prot <= unpack_wdata(sr_wdata);
        end
    end

    assert_lock_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (sr_wr && !wp_n && prot.lock) |=> ($stable(prot.bp) && $stable(prot.lock)));
    assert_pin_high_load_R2: assert property (@(posedge clk) disable iff (rst)
        (sr_wr && wp_n) |=> (prot.bp == $past(sr_wdata[5:2]) && prot.lock == $past(sr_wdata[7])));
    assert_no_strobe_hold_R11: assert property (@(posedge clk) disable iff (rst)
        !sr_wr |=> $stable(prot));
endmodule

// File: rtl/wp_region_decode.sv
module wp_region_decode #(
    parameter int ADDR_W = 20
) (
    input  logic [2:0]        code,
    input  logic [ADDR_W-1:0] addr,
    output logic              in_region
);
    localparam int STEPS = 4;
    logic [7:0] hit;

    assign hit[0] = 1'b0;
    for (genvar k = 1; k <= STEPS; k++) begin : g_frac
        assign hit[k] = &addr[ADDR_W-1 -: (STEPS + 1 - k)];
    end
    for (genvar k = STEPS + 1; k < 8; k++) begin : g_all
        assign hit[k] = 1'b1;
    end

    assign in_region = hit[code];
endmodule

// File: rtl/wp_judge.sv
module wp_judge
    import wp_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic req_valid,
    input  logic req_chip,
    input  logic in_region,
    input  logic bp_zero,
    input  logic [2:0] code,
    output logic grant,
    output logic deny
);
    verdict_e verdict_q, verdict_d;

    always_comb begin
        verdict_d = V_IDLE;
        if (req_valid) begin
            if (req_chip) verdict_d = bp_zero ? V_GRANT : V_DENY;
            else          verdict_d = in_region ? V_DENY : V_GRANT;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) verdict_q <= V_IDLE;
        else     verdict_q <= verdict_d;
    end

    assign grant = (verdict_q == V_GRANT);
    assign deny  = (verdict_q == V_DENY);

    assert_exclusive_R10: assert property (@(posedge clk) disable iff (rst) !(grant && deny));
    assert_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!grant && !deny));
    assert_answer_R10: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> (grant || deny));
    assert_chip_locked_R9: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_chip && !bp_zero) |=> deny);
    assert_open_R5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_chip && code == 3'b000) |=> grant);
    assert_whole_R7: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_chip && code >= 3'd5) |=> deny);
endmodule

// File: rtl/wp_ctrl.sv
module wp_ctrl
    import wp_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                sr_wr,
    input  logic [STATUS_W-1:0] sr_wdata,
    input  logic                wp_n,
    input  logic [2:0]          aux,
    input  logic                req_valid,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic                req_chip,
    output logic [STATUS_W-1:0] status,
    output logic                grant,
    output logic                deny
);
    prot_t prot;
    logic  in_region;
    logic  bp_zero;

    wp_status_reg u_sreg (
        .clk(clk), .rst(rst), .sr_wr(sr_wr), .sr_wdata(sr_wdata),
        .wp_n(wp_n), .prot(prot)
    );

    wp_region_decode #(.ADDR_W(ADDR_W)) u_dec (
        .code(prot.bp[2:0]), .addr(req_addr), .in_region(in_region)
    );

    assign bp_zero = (prot.bp == '0);

    wp_judge u_judge (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_chip(req_chip),
        .in_region(in_region), .bp_zero(bp_zero), .code(prot.bp[2:0]),
        .grant(grant), .deny(deny)
    );

    assign status = pack_status(prot, aux);

    always_comb begin
        assert_side_bits_R12: assert (status[0] == aux[0] && status[1] == aux[1] && status[6] == aux[2]);
    end
endmodule

// File: tb/wp_ctrl_test.sv
module wp_ctrl_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sr_wr = 1'b0;
    logic [7:0]  sr_wdata = '0;
    logic        wp_n = 1'b1;
    logic [2:0]  aux = 3'b000;
    logic        req_valid = 1'b0;
    logic [19:0] req_addr = '0;
    logic        req_chip = 1'b0;
    logic [7:0]  status;
    logic        grant, deny;

    int tests = 0;
    int fails = 0;
    bit started = 0;
    bit done = 0;

    typedef struct {
        logic  g;
        logic  d;
        string tag;
    } exp_t;
    exp_t q[$];

    logic [3:0] m_bp;
    logic       m_lock;

    always #5 clk = ~clk;

    wp_ctrl uut (
        .clk(clk), .rst(rst), .sr_wr(sr_wr), .sr_wdata(sr_wdata), .wp_n(wp_n),
        .aux(aux), .req_valid(req_valid), .req_addr(req_addr), .req_chip(req_chip),
        .status(status), .grant(grant), .deny(deny)
    );

    function automatic logic prot_hit(input logic [3:0] bp, input logic [19:0] a);
        case (bp[2:0])
            3'd0: return 1'b0;
            3'd1: return a >= 20'hF0000;
            3'd2: return a >= 20'hE0000;
            3'd3: return a >= 20'hC0000;
            3'd4: return a >= 20'h80000;
            default: return 1'b1;
        endcase
    endfunction

    task automatic step(input logic rv, input logic [19:0] a, input logic ce,
                        input logic sw, input logic [7:0] wd, input string tag);
        exp_t e;
        @(negedge clk);
        req_valid = rv; req_addr = a; req_chip = ce; sr_wr = sw; sr_wdata = wd;
        e.tag = tag;
        if (!rv) begin e.g = 0; e.d = 0; end
        else begin
            logic ok;
            ok = ce ? (m_bp == 4'b0) : !prot_hit(m_bp, a);
            e.g = ok; e.d = !ok;
        end
        q.push_back(e);
        if (sw && (wp_n || !m_lock)) begin
            m_lock = wd[7];
            m_bp   = wd[5:2];
        end
    endtask

    task automatic check_status(input string tag);
        logic [7:0] exp;
        step(0, '0, 0, 0, '0, tag);
        exp = {m_lock, aux[2], m_bp, aux[1], aux[0]};
        tests++;
        if (status !== exp) begin
            fails++;
            $display("FAIL %s status actual=%02h expected=%02h", tag, status, exp);
        end
    endtask

    task automatic set_bp(input logic [3:0] bp, input logic lk);
        step(0, '0, 0, 1, {lk, 1'b0, bp, 2'b00}, "R2");
    endtask

    task automatic req(input logic [19:0] a, input logic ce, input string tag);
        step(1, a, ce, 0, '0, tag);
    endtask

    // monitor / scoreboard
    always @(posedge clk) begin
        #1;
        if (started && q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            tests++;
            if (grant !== e.g || deny !== e.d) begin
                fails++;
                $display("FAIL %s grant/deny actual=%b%b expected=%b%b", e.tag, grant, deny, e.g, e.d);
            end
        end
    end

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 20000) begin
                fails++; tests++;
                $display("FAIL watchdog expired");
                $display("[TB] %0d tests run, %0d failed", tests, fails);
                $finish;
            end
        end
    end

    initial begin
        logic [19:0] bounds [1:4];
        bounds[1] = 20'hF0000; bounds[2] = 20'hE0000;
        bounds[3] = 20'hC0000; bounds[4] = 20'h80000;
        m_bp = 4'hF; m_lock = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        started = 1;
        check_status("R1");
        req(20'h00000, 0, "R7");
        req(20'h00000, 1, "R9");

        // R12 side bits
        aux = 3'b101; check_status("R12");
        aux = 3'b010; check_status("R12");
        aux = 3'b000;

        // R5 open
        set_bp(4'b0000, 0); check_status("R2");
        req(20'h00000, 0, "R5"); req(20'hFFFFF, 0, "R5"); req(20'h7FFFF, 0, "R5");
        req(20'h12345, 1, "R9");

        // R6 fractions, R8 with bp3 both values
        for (int k = 1; k <= 4; k++) begin
            for (int b3 = 0; b3 < 2; b3++) begin
                set_bp({b3[0], k[2:0]}, 0);
                req(bounds[k], 0, b3 ? "R8" : "R6");
                req(bounds[k] - 20'd1, 0, b3 ? "R8" : "R6");
                req(20'hFFFFF, 0, "R6");
                req(20'h00000, 1, "R9");
            end
        end
        // R7 whole array
        for (int c = 5; c < 8; c++) begin
            set_bp({1'b0, c[2:0]}, 0);
            req(20'h00000, 0, "R7"); req(20'h7FFFF, 0, "R7");
        end
        // R8: bp3 alone; R9 chip denied by bp3 only
        set_bp(4'b1000, 0);
        req(20'hFFFFF, 0, "R8"); req(20'h00000, 1, "R9");

        // R11: write and request in the same cycle
        set_bp(4'b0000, 0);
        step(1, 20'hFFFFF, 0, 1, 8'b0001_1100, "R11");
        req(20'hFFFFF, 0, "R11");
        check_status("R11");

        // R3: pin low, lock clear -> write loads, set lock
        wp_n = 0;
        step(0, '0, 0, 1, 8'b1000_1000, "R3"); check_status("R3");
        // R4: pin low, lock set -> frozen
        step(0, '0, 0, 1, 8'b0000_0000, "R4"); check_status("R4");
        req(20'h00000, 1, "R4"); req(20'hFFFFF, 0, "R4");
        // R2: pin high overrides lock
        wp_n = 1;
        step(0, '0, 0, 1, 8'b0000_0000, "R2"); check_status("R2");
        req(20'h00000, 1, "R2");

        // R10: back-to-back requests then idle
        req(20'h00001, 0, "R10"); req(20'hFFFFF, 0, "R10");
        step(0, '0, 0, 0, '0, "R10"); step(0, '0, 0, 0, '0, "R10");
        repeat (3) @(negedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule